// File: doc/BRIEF.md
# Multidrop Nine-Bit Serial Receiver with Address Filter

This block receives characters from a shared multidrop serial line on which a ninth bit follows the eight data bits. The ninth bit tells an address character (1) from a data character (0). The block keeps a receive gate. While the gate is closed, data characters are thrown away and only address characters come through. The host can open or close the gate directly. In automatic mode, hardware opens the gate when an address character names this station or the broadcast address, and closes it again when an address names another station.

The station address and an address mask come from two configuration registers. Mask bits at 0 make the matching address bits don't-care. In a unicast match, every bit where the mask is 1 must equal the station address. The broadcast pattern is the station address OR the inverted mask, and an incoming address matches it when it has a 1 in every position where that pattern is 1. With the mode bit clear, the block works as a plain 8N1 receiver and delivers every character.

The line is sampled against a 16x oversampling tick. Each bit is taken at its mid-point. Received bytes appear with a one-cycle valid strobe. A frame whose stop bit is missing raises a one-cycle framing-error pulse and is not delivered.

Top module: `mdrop_rx`

## Requirements
- R1: After reset the gate output is 1, the receiver is in plain 8-bit mode, automatic addressing is off, and neither the valid strobe nor the error pulse is active.
- R2: In plain mode (control register, selector 0, bit 0 = 0) a frame is one low start bit, 8 data bits LSB first and one high stop bit. Every such frame is delivered on rx_data_o with rx_addr_o = 0, whatever the gate state.
- R3: In nine-bit mode (selector 0, bit 0 = 1) a frame has a ninth bit between data bit 7 and the stop bit, and that bit is presented on rx_addr_o together with the byte.
- R4: In nine-bit mode with the gate at 1, characters whose ninth bit is 0 produce no valid strobe, and characters whose ninth bit is 1 are delivered.
- R5: A write to selector 3 loads wdata bit 0 into the gate. With the gate at 0, data characters in nine-bit mode are delivered.
- R6: With automatic addressing off (selector 0, bit 1 = 0), received address characters leave the gate unchanged.
- R7: With nine-bit mode and automatic addressing on, an address character that equals the station address (selector 1) in every bit where the mask (selector 2) is 1 clears the gate.
- R8: In the same mode, an address character that has a 1 in every bit where (station address OR NOT mask) is 1 clears the gate.
- R9: In the same mode, an address character that matches neither pattern sets the gate, so data characters that follow it are dropped.
- R10: The automatic-addressing bit has no effect in plain mode: frames are delivered and the gate keeps its value.
- R11: A frame whose stop bit samples 0 produces one error pulse on frame_err_o and no valid strobe, and it leaves the gate unchanged.
- R12: A low pulse on the line that is shorter than half a bit time is not taken as a start bit and produces neither a character nor an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, already synchronised, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 station address, 2 mask, 3 gate |
| cfg_wdata_i | input | 8 | Register write data |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o and rx_addr_o |
| rx_addr_o | output | 1 | Ninth bit of the delivered character |
| frame_err_o | output | 1 | One-cycle pulse for a frame with a bad stop bit |
| gate_o | output | 1 | Current receive gate: 1 means data characters are dropped |

## Verification
The scoreboard runs four kinds of traffic. Plain frames with the gate closed show that gating is tied to the nine-bit mode. In manual mode, a mix of data and address characters shows that the ninth bit alone decides what is dropped. In automatic mode, addresses are chosen to hit only the unicast pattern, only the broadcast pattern, or neither, and each choice leaves a distinct gate value followed by a distinct delivery outcome for the next data character. A frame with a broken stop bit and a short start glitch show that error cases and line noise are kept apart from real characters.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SADDR = 2'd1,
    SEL_SADEN = 2'd2,
    SEL_GATE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_NINE_BIT = 0;
  localparam int unsigned CTRL_AUTO_BIT = 1;
  localparam int unsigned GATE_BIT      = 0;

endpackage

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
  import mdrop_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              nine_en_i,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o,
  output logic              frame_nine_o
);

  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              ninth_q;
  logic              nine_q;
  logic              at_mid;

  assign at_mid = tick_i && (cnt_q == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      ninth_q <= 1'b0;
      nine_q  <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (!rx_i) state_q <= ST_START;
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_q <= '0;
            if (!rx_i) begin
              // frame format fixed for the whole character
              state_q <= ST_DATA;
              idx_q   <= '0;
              ninth_q <= 1'b0;
              nine_q  <= nine_en_i;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_FULL) begin
            shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) state_q <= nine_q ? ST_NINTH : ST_STOP;
            else idx_q <= idx_q + 1'b1;
          end
        end
        ST_NINTH: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_FULL) begin
            ninth_q <= rx_i;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_FULL) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o       = at_mid && (state_q == ST_STOP);
  assign stop_ok_o    = rx_i;
  assign data_o       = shreg_q;
  assign ninth_o      = ninth_q;
  assign frame_nine_o = nine_q;

endmodule

// File: rtl/mdrop_rx_match.sv
module mdrop_rx_match #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] saddr_i,
  input  logic [DATA_W-1:0] saden_i,
  output logic              hit_given_o,
  output logic              hit_bcast_o
);

  logic [DATA_W-1:0] bcast_pat;
  logic [DATA_W-1:0] given_ok;
  logic [DATA_W-1:0] bcast_ok;

  assign bcast_pat = saddr_i | ~saden_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign given_ok[b] = ~saden_i[b] | (addr_i[b] == saddr_i[b]);
    assign bcast_ok[b] = ~bcast_pat[b] | addr_i[b];
  end

  assign hit_given_o = &given_ok;
  assign hit_bcast_o = &bcast_ok;

endmodule

// File: rtl/mdrop_rx_regs.sv
module mdrop_rx_regs
  import mdrop_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_set_i,
  input  logic              hw_clr_i,
  output logic              nine_o,
  output logic              auto_o,
  output logic [DATA_W-1:0] saddr_o,
  output logic [DATA_W-1:0] saden_o,
  output logic              gate_o
);

  logic              nine_q;
  logic              auto_q;
  logic [DATA_W-1:0] saddr_q;
  logic [DATA_W-1:0] saden_q;
  logic              gate_q;
  logic              host_gate;

  assign host_gate = we_i && (sel_i == SEL_GATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nine_q  <= 1'b0;
      auto_q  <= 1'b0;
      saddr_q <= '0;
      saden_q <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_CTRL: begin
          nine_q <= wdata_i[CTRL_NINE_BIT];
          auto_q <= wdata_i[CTRL_AUTO_BIT];
        end
        SEL_SADDR: saddr_q <= wdata_i;
        SEL_SADEN: saden_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // host write wins over a hardware update in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gate_q <= 1'b1;
    else if (host_gate) gate_q <= wdata_i[GATE_BIT];
    else if (hw_clr_i)  gate_q <= 1'b0;
    else if (hw_set_i)  gate_q <= 1'b1;
  end

  assign nine_o  = nine_q;
  assign auto_o  = auto_q;
  assign saddr_o = saddr_q;
  assign saden_o = saden_q;
  assign gate_o  = gate_q;

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_addr_o,
  output logic              frame_err_o,
  output logic              gate_o
);

  logic              fr_done;
  logic              fr_stop_ok;
  logic [DATA_W-1:0] fr_data;
  logic              fr_ninth;
  logic              frame_nine;

  logic              nine_en;
  logic              auto_en;
  logic [DATA_W-1:0] saddr;
  logic [DATA_W-1:0] saden;
  logic              gate;

  logic              hit_given;
  logic              hit_bcast;

  logic              accept;
  logic              hw_clr;
  logic              hw_set;

  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              addr_q;
  logic              err_q;

  mdrop_rx_frame #(
    .DATA_W(DATA_W),
    .OSR   (OSR)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_i        (rx_i),
    .tick_i      (tick_i),
    .nine_en_i   (nine_en),
    .done_o      (fr_done),
    .stop_ok_o   (fr_stop_ok),
    .data_o      (fr_data),
    .ninth_o     (fr_ninth),
    .frame_nine_o(frame_nine)
  );

  mdrop_rx_match #(
    .DATA_W(DATA_W)
  ) u_match (
    .addr_i     (fr_data),
    .saddr_i    (saddr),
    .saden_i    (saden),
    .hit_given_o(hit_given),
    .hit_bcast_o(hit_bcast)
  );

  mdrop_rx_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .hw_set_i(hw_set),
    .hw_clr_i(hw_clr),
    .nine_o  (nine_en),
    .auto_o  (auto_en),
    .saddr_o (saddr),
    .saden_o (saden),
    .gate_o  (gate)
  );

  always_comb begin
    accept = 1'b0;
    hw_clr = 1'b0;
    hw_set = 1'b0;
    if (fr_done && fr_stop_ok) begin
      if (!frame_nine) begin
        accept = 1'b1;
      end else if (fr_ninth) begin
        accept = 1'b1;
        if (auto_en) begin
          if (hit_given || hit_bcast) hw_clr = 1'b1;
          else                        hw_set = 1'b1;
        end
      end else begin
        accept = !gate;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= accept;
      err_q   <= fr_done && !fr_stop_ok;
      if (accept) begin
        data_q <= fr_data;
        addr_q <= fr_ninth && frame_nine;
      end
    end
  end

  assign rx_data_o   = data_q;
  assign rx_valid_o  = valid_q;
  assign rx_addr_o   = addr_q;
  assign frame_err_o = err_q;
  assign gate_o      = gate;

endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_we_i,
  input logic rx_valid_o,
  input logic rx_addr_o,
  input logic frame_err_o,
  input logic gate_o,
  input logic frame_nine_i
);

  // R11: an error frame is never delivered
  assert_err_not_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && frame_err_o));

  // R11: an error frame leaves the gate alone
  assert_err_keeps_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !$past(cfg_we_i)) |-> $stable(gate_o));

  // R4: no data character passes a closed gate in nine-bit mode
  assert_gate_blocks_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_addr_o && frame_nine_i) |-> !$past(gate_o));

  // R7: the gate opens only through the host or an address character
  assert_gate_fall_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> ($past(cfg_we_i) || (rx_valid_o && rx_addr_o)));

  // R9: the gate closes only through the host or an address character
  assert_gate_rise_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> ($past(cfg_we_i) || (rx_valid_o && rx_addr_o)));

  // R2: plain frames never carry an address flag
  assert_addr_only_nine_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_addr_o) |-> frame_nine_i);

endmodule

bind mdrop_rx mdrop_rx_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .rx_valid_o  (rx_valid_o),
  .rx_addr_o   (rx_addr_o),
  .frame_err_o (frame_err_o),
  .gate_o      (gate_o),
  .frame_nine_i(frame_nine)
);

// File: tb/mdrop_rx_tb_top.sv
module mdrop_rx_tb_top;

  localparam int unsigned CLK_HALF = 2;   // 250 MHz
  localparam int unsigned TICK_DIV = 2;
  localparam int unsigned OSR      = 16;
  localparam int unsigned BIT_CYC  = OSR * TICK_DIV;

  typedef struct {
    logic [7:0] data;
    logic       addr;
    string      tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_sel_i = 2'd0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_addr_o;
  logic       frame_err_o;
  logic       gate_o;

  int   checks = 0;
  int   errors = 0;
  int   err_pulses = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_HALF) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_i <= 1'b0;
    else         tick_i <= ~tick_i;
  end

  mdrop_rx dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .tick_i     (tick_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_addr_o  (rx_addr_o),
    .frame_err_o(frame_err_o),
    .gate_o     (gate_o)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: pops the scoreboard on every delivered character
  always @(negedge clk_i) begin
    if (rst_ni && frame_err_o) err_pulses++;
    if (rst_ni && rx_valid_o) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected delivery actual=%02h/%0b expected=none", rx_data_o, rx_addr_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rx_data_o !== e.data || rx_addr_o !== e.addr) begin
          errors++;
          $display("FAIL %s actual=%02h/%0b expected=%02h/%0b",
                   e.tag, rx_data_o, rx_addr_o, e.data, e.addr);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic drive_bit(input logic b, input int cyc);
    rx_i = b;
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] d, input logic ninth, input bit nine,
                      input bit stop_ok, input bit expect_out, input string tag);
    if (expect_out) sb_q.push_back('{d, ninth & nine, tag});
    @(negedge clk_i);
    drive_bit(1'b0, BIT_CYC);
    for (int i = 0; i < 8; i++) drive_bit(d[i], BIT_CYC);
    if (nine) drive_bit(ninth, BIT_CYC);
    if (stop_ok) drive_bit(1'b1, BIT_CYC);
    else         drive_bit(1'b0, BIT_CYC * 10 / 16);
    drive_bit(1'b1, BIT_CYC + 8);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL %s actual=missing expected=%02h", sb_q[0].tag, sb_q[0].data);
      sb_q.delete();
    end
  endtask

  task automatic chk_gate(input logic exp, input string tag);
    @(negedge clk_i);
    check(gate_o === exp, tag, int'(gate_o), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    check(gate_o === 1'b1, "R1 gate", int'(gate_o), 1);
    check(rx_valid_o === 1'b0 && frame_err_o === 1'b0, "R1 strobes",
          int'({rx_valid_o, frame_err_o}), 0);

    // R2: plain frames pass a closed gate
    send(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, "R2 plain A5");
    send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, "R2 plain 3C");
    chk_gate(1'b1, "R2 gate untouched");

    // R12: short glitch is no start bit
    e0 = err_pulses;
    drive_bit(1'b0, 3 * TICK_DIV);
    drive_bit(1'b1, BIT_CYC * 12);
    check(err_pulses == e0, "R12 glitch no error", err_pulses, e0);

    // R10: auto bit alone does nothing
    wr(2'd1, 8'h12);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h02);
    send(8'h55, 1'b0, 1'b0, 1'b1, 1'b1, "R10 plain with auto");
    send(8'h12, 1'b0, 1'b0, 1'b1, 1'b1, "R10 plain station byte");
    chk_gate(1'b1, "R10 gate unchanged");

    // manual nine-bit mode
    wr(2'd0, 8'h01);
    send(8'h11, 1'b0, 1'b1, 1'b1, 1'b0, "R4 data dropped");
    send(8'h40, 1'b1, 1'b1, 1'b1, 1'b1, "R3 address delivered");
    chk_gate(1'b1, "R6 address keeps gate");
    wr(2'd3, 8'h00);
    chk_gate(1'b0, "R5 host clear");
    send(8'h77, 1'b0, 1'b1, 1'b1, 1'b1, "R5 data after clear");
    send(8'h99, 1'b1, 1'b1, 1'b1, 1'b1, "R6 foreign address");
    chk_gate(1'b0, "R6 gate still open");
    wr(2'd3, 8'h01);
    chk_gate(1'b1, "R5 host set");

    // automatic nine-bit mode: unicast 0001xxxx, broadcast xxx11111
    wr(2'd1, 8'h12);
    wr(2'd2, 8'hF0);
    wr(2'd0, 8'h03);
    send(8'h22, 1'b0, 1'b1, 1'b1, 1'b0, "R4 data dropped auto");
    send(8'h1A, 1'b1, 1'b1, 1'b1, 1'b1, "R7 unicast address");
    chk_gate(1'b0, "R7 gate opened");
    send(8'h33, 1'b0, 1'b1, 1'b1, 1'b1, "R7 data after unicast");
    send(8'h25, 1'b1, 1'b1, 1'b1, 1'b1, "R9 foreign address");
    chk_gate(1'b1, "R9 gate closed");
    send(8'h44, 1'b0, 1'b1, 1'b1, 1'b0, "R9 data dropped");
    send(8'hDF, 1'b1, 1'b1, 1'b1, 1'b1, "R8 broadcast address");
    chk_gate(1'b0, "R8 gate opened");
    send(8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, "R8 data after broadcast");

    // R11: broken stop bit on a foreign address
    e0 = err_pulses;
    send(8'h25, 1'b1, 1'b1, 1'b0, 1'b0, "R11 framing error");
    check(err_pulses == e0 + 1, "R11 one error pulse", err_pulses, e0 + 1);
    chk_gate(1'b0, "R11 gate unchanged");

    done = 1'b1;
    report();
    $finish;
  end

endmodule